// File: doc/BRIEF.md
# Alternator Field PWM Generator with Load-Response Ramp

This block drives the field winding of an alternator with a fixed-frequency pulse-width signal. A sequencer selects one of three operating modes: field off, a fixed low pre-excitation duty, or closed-loop regulation. In regulation the duty is proportional to the digitized voltage error (setpoint minus sensed voltage, in millivolts). Zero error gives zero duty, and the duty saturates at full field once the error reaches the proportional band of 100 mV.

Increases in duty during regulation can be slew-limited so that a sudden electrical load does not put a step torque on the engine. The limit comes from one of sixteen ramp times, spaced roughly geometrically between 0.426 s and 13.2 s for a sweep from zero to full field. Above a programmable generator speed the limit is bypassed, unless the cutoff is configured as always active. After an engine-start indication, the first ramp to full field is always limited, at any speed. Decreases in duty always take effect at once.

The duty is an 8-bit value that changes only at PWM period boundaries. The period length comes from a clock-frequency parameter, so a scaled-down clock gives a short period.

Top module: `field_pwm`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `field_out` is low, the applied duty is 0 and no first-ramp obligation is pending.
- R2: A PWM period is 256 slots, each SLOT_CYC clock cycles long (SLOT_CYC = CLK_HZ / (PWM_HZ*256), at least 1). With applied duty d, `field_out` is high in slots 0 to d-1 and low in the rest. Duty 255 keeps the output high for the whole period, and duty 0 keeps it low.
- R3: The inputs are sampled, and a new duty is computed, only in the last cycle of slot 255. The new duty applies from the following slot 0. Input changes in the middle of a period have no effect until that point.
- R4: In regulate mode (mode code 2), the target duty is 0 for an error of 0 mV or less, 255 for an error of 100 mV or more, and floor(err*255/100) between those.
- R5: In pre-excitation mode (mode code 1), the applied duty becomes 48 (18.75 %) at the next boundary, without rate limiting.
- R6: Mode codes 0 and 3 set the applied duty to 0 at the next boundary.
- R7: The applied duty is the upper byte of a 16-bit accumulator. A limited rise adds at most floor(65280/P) per period, where P for `ramp_sel` 0..15 is 64, 80, 101, 127, 160, 201, 253, 318, 400, 503, 632, 795, 1000, 1258, 1582, 1980. The accumulator never overshoots the target (target duty * 256).
- R8: When the target is at or below the accumulator, the accumulator takes the target value at the next boundary, in any mode.
- R9: Rises are limited when `cutoff_code` is 0, or when `speed_rpm` is below 2400 + 400*(cutoff_code-1). Otherwise the target duty is applied at the next boundary.
- R10: A high `engine_start` sets a first-ramp obligation. While the obligation is set, regulation rises are limited regardless of speed. It clears at the boundary where the accumulator reaches 0xFF00 in regulate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 off, 1 pre-excitation, 2 regulate, 3 off |
| volt_err_mv | input | 16 | Signed voltage error in mV |
| ramp_sel | input | 4 | Ramp-time selection |
| cutoff_code | input | 4 | 0 always limit, else cutoff speed code |
| speed_rpm | input | 16 | Generator speed in RPM |
| engine_start | input | 1 | Engine-start indication, arms the first-ramp limit |
| field_out | output | 1 | Field PWM drive |

## Verification
Any input change shows at `field_out` only at the period boundary: the bench samples the inputs on the clock edge that ends slot 255, and the new duty drives the output from the first cycle of slot 0. The bench's reference model advances a slot and period counter on the same edges and applies its own duty update at that boundary, so the expected waveform has the same one-period latency. It compares `field_out` against the model away from the clock edge on every cycle. Some input changes land in the middle of a period, to show that nothing moves before the boundary.

// File: rtl/field_pwm_pkg.sv
package field_pwm_pkg;

  localparam int DUTY_W   = 8;
  localparam int ACC_W    = 16;
  localparam int SLOTS    = 256;
  localparam logic [ACC_W-1:0] ACC_FULL = 16'hFF00;

  typedef enum logic [1:0] {
    FM_OFF    = 2'd0,
    FM_PREEXC = 2'd1,
    FM_REG    = 2'd2,
    FM_SPARE  = 2'd3
  } field_mode_e;

  // proportional duty from error, saturating at the band edge
  function automatic logic [DUTY_W-1:0] prop_duty(input logic signed [15:0] err_mv,
                                                  input int band_mv);
    int e;
    int d;
    e = int'(err_mv);
    if (e <= 0)            d = 0;
    else if (e >= band_mv) d = 255;
    else                   d = (e * 255) / band_mv;
    return DUTY_W'(d);
  endfunction

  // PWM periods for a zero-to-full sweep, roughly geometric
  function automatic int ramp_periods(input logic [3:0] sel);
    case (sel)
      4'd0:  return 64;
      4'd1:  return 80;
      4'd2:  return 101;
      4'd3:  return 127;
      4'd4:  return 160;
      4'd5:  return 201;
      4'd6:  return 253;
      4'd7:  return 318;
      4'd8:  return 400;
      4'd9:  return 503;
      4'd10: return 632;
      4'd11: return 795;
      4'd12: return 1000;
      4'd13: return 1258;
      4'd14: return 1582;
      default: return 1980;
    endcase
  endfunction

  // accumulator increment per period
  function automatic logic [ACC_W-1:0] ramp_inc(input logic [3:0] sel);
    return ACC_W'(int'(ACC_FULL) / ramp_periods(sel));
  endfunction

  // cutoff speed for a non-zero code
  function automatic logic [15:0] cutoff_rpm(input logic [3:0] code,
                                             input int base_rpm,
                                             input int step_rpm);
    int c;
    c = (code == 4'd0) ? 0 : int'(code) - 1;
    return 16'(base_rpm + step_rpm * c);
  endfunction

endpackage

// File: rtl/fpwm_timebase.sv
module fpwm_timebase #(
  parameter int SLOT_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [7:0] slot,
  output logic       slot_tick,
  output logic       period_tick
);
  localparam int PRE_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [7:0] slot_q;

  generate
    if (SLOT_CYC <= 1) begin : g_direct
      assign slot_tick = 1'b1;
    end else begin : g_prescale
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              pre_q <= '0;
        else if (pre_q == PRE_W'(SLOT_CYC - 1))  pre_q <= '0;
        else                                     pre_q <= pre_q + 1'b1;
      end
      assign slot_tick = (pre_q == PRE_W'(SLOT_CYC - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         slot_q <= '0;
    else if (slot_tick) slot_q <= slot_q + 8'd1;
  end

  assign slot        = slot_q;
  assign period_tick = slot_tick && (slot_q == 8'hFF);

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> slot_q == 8'($past(slot_q) + 8'd1));

  p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(slot_q));

endmodule

// File: rtl/fpwm_ramp.sv
module fpwm_ramp
  import field_pwm_pkg::*;
#(
  parameter int BAND_MV     = 100,
  parameter int PREEXC_DUTY = 48,
  parameter int CUT_BASE    = 2400,
  parameter int CUT_STEP    = 400
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               period_tick,
  input  logic [1:0]         mode,
  input  logic signed [15:0] volt_err_mv,
  input  logic [3:0]         ramp_sel,
  input  logic [3:0]         cutoff_code,
  input  logic [15:0]        speed_rpm,
  input  logic               engine_start,
  output logic [DUTY_W-1:0]  duty,
  output logic               limit_en,
  output logic               first_pend
);
  logic [ACC_W-1:0] acc_q, acc_nxt, tgt_acc, inc;
  logic [ACC_W:0]   sum_ext;
  logic             pend_q, pend_nxt;
  logic             is_reg, below_cut;

  assign is_reg    = (field_mode_e'(mode) == FM_REG);
  assign below_cut = speed_rpm < cutoff_rpm(cutoff_code, CUT_BASE, CUT_STEP);
  assign limit_en  = is_reg && ((cutoff_code == 4'd0) || below_cut || pend_q);
  assign inc       = ramp_inc(ramp_sel);
  assign sum_ext   = {1'b0, acc_q} + {1'b0, inc};

  always_comb begin
    case (field_mode_e'(mode))
      FM_REG:    tgt_acc = {prop_duty(volt_err_mv, BAND_MV), 8'h00};
      FM_PREEXC: tgt_acc = {8'(PREEXC_DUTY), 8'h00};
      default:   tgt_acc = '0;
    endcase
  end

  always_comb begin
    if (tgt_acc <= acc_q)                  acc_nxt = tgt_acc;
    else if (!limit_en)                    acc_nxt = tgt_acc;
    else if (sum_ext >= {1'b0, tgt_acc})   acc_nxt = tgt_acc;
    else                                   acc_nxt = sum_ext[ACC_W-1:0];
  end

  always_comb begin
    pend_nxt = pend_q;
    if (period_tick && is_reg && (acc_nxt >= ACC_FULL)) pend_nxt = 1'b0;
    if (engine_start)                                   pend_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      if (period_tick) acc_q <= acc_nxt;
    end
  end

  assign duty       = acc_q[ACC_W-1:8];
  assign first_pend = pend_q;

  p_hold_midperiod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !period_tick |=> $stable(acc_q));

  p_rise_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick && limit_en |=> {1'b0, acc_q} <= $past(sum_ext));

  p_no_overshoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> acc_q <= $past(tgt_acc) || $past(tgt_acc) < $past(acc_q) || 1'b0);

  p_drop_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick && (tgt_acc <= acc_q) |=> acc_q == $past(tgt_acc));

  p_preexc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick && (mode == 2'd1) |=> duty == 8'(PREEXC_DUTY));

  p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick && (mode == 2'd0 || mode == 2'd3) |=> duty == 8'd0);

  p_pend_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !period_tick |=> pend_q);

endmodule

// File: rtl/fpwm_modulator.sv
module fpwm_modulator #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] duty,
  input  logic [7:0]    slot,
  output logic          pwm
);
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};

  assign pwm = (duty == DMAX) || (slot < duty);

endmodule

// File: rtl/field_pwm.sv
module field_pwm
  import field_pwm_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int PWM_HZ      = 150,
  parameter int BAND_MV     = 100,
  parameter int PREEXC_DUTY = 48,
  parameter int CUT_BASE    = 2400,
  parameter int CUT_STEP    = 400
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic signed [15:0] volt_err_mv,
  input  logic [3:0]         ramp_sel,
  input  logic [3:0]         cutoff_code,
  input  logic [15:0]        speed_rpm,
  input  logic               engine_start,
  output logic               field_out
);
  localparam int SLOT_RAW = CLK_HZ / (PWM_HZ * SLOTS);
  localparam int SLOT_CYC = (SLOT_RAW < 1) ? 1 : SLOT_RAW;

  logic [7:0]        slot;
  logic              slot_tick, period_tick;
  logic [DUTY_W-1:0] duty;
  logic              limit_en, first_pend;

  fpwm_timebase #(.SLOT_CYC(SLOT_CYC)) u_tb (
    .clk(clk), .rst_n(rst_n), .slot(slot),
    .slot_tick(slot_tick), .period_tick(period_tick)
  );

  fpwm_ramp #(
    .BAND_MV(BAND_MV), .PREEXC_DUTY(PREEXC_DUTY),
    .CUT_BASE(CUT_BASE), .CUT_STEP(CUT_STEP)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .mode(mode),
    .volt_err_mv(volt_err_mv), .ramp_sel(ramp_sel), .cutoff_code(cutoff_code),
    .speed_rpm(speed_rpm), .engine_start(engine_start),
    .duty(duty), .limit_en(limit_en), .first_pend(first_pend)
  );

  fpwm_modulator #(.DW(DUTY_W)) u_mod (
    .duty(duty), .slot(slot), .pwm(field_out)
  );

  p_full_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    duty == 8'hFF |-> field_out);

  p_zero_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    duty == 8'h00 |-> !field_out);

  p_first_limited_r10: assert property (@(posedge clk) disable iff (!rst_n)
    first_pend && (mode == 2'd2) |-> limit_en);

  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |=> !field_out);

endmodule

// File: tb/test_field_pwm.sv
module test_field_pwm;
  localparam int CLK_HZ = 38_400;
  localparam int PWM_HZ = 150;
  localparam int SC     = 1;
  localparam int PER    = 256 * SC;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         mode = 2'd0;
  logic signed [15:0] volt_err_mv = '0;
  logic [3:0]         ramp_sel = '0;
  logic [3:0]         cutoff_code = '0;
  logic [15:0]        speed_rpm = '0;
  logic               engine_start = 1'b0;
  logic               field_out;

  always #10 clk = ~clk;

  field_pwm #(.CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ)) i_field_pwm (
    .clk(clk), .rst_n(rst_n), .mode(mode), .volt_err_mv(volt_err_mv),
    .ramp_sel(ramp_sel), .cutoff_code(cutoff_code), .speed_rpm(speed_rpm),
    .engine_start(engine_start), .field_out(field_out)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_pre, m_slot, m_acc;
  bit m_pend;
  int per_tab [16] = '{64, 80, 101, 127, 160, 201, 253, 318,
                       400, 503, 632, 795, 1000, 1258, 1582, 1980};

  function automatic int want_duty(int md, int e);
    if (md == 1) return 48;
    if (md != 2) return 0;
    if (e <= 0) return 0;
    if (e >= 100) return 255;
    return (e * 255) / 100;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_slot = 0; m_acc = 0; m_pend = 0;
    end else begin
      if (m_pre == SC - 1 && m_slot == 255) begin
        int tgt, lim, nxt, cut;
        tgt = want_duty(int'(mode), int'(volt_err_mv)) * 256;
        cut = 2400 + 400 * (int'(cutoff_code) - 1);
        lim = (mode == 2'd2) && (cutoff_code == 0 || int'(speed_rpm) < cut || m_pend);
        if (tgt <= m_acc || !lim) nxt = tgt;
        else nxt = (m_acc + 65280 / per_tab[ramp_sel] >= tgt) ? tgt
                   : m_acc + 65280 / per_tab[ramp_sel];
        m_acc = nxt;
        if (mode == 2'd2 && nxt >= 65280) m_pend = 0;
      end
      if (engine_start) m_pend = 1;
      if (m_pre == SC - 1) begin m_pre = 0; m_slot = (m_slot + 1) % 256; end
      else m_pre++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int d;
      bit exp;
      d = m_acc / 256;
      exp = (d == 255) || (m_slot < d);
      checks++;
      if (field_out !== exp) begin
        errors++;
        if (errors < 20)
          $display("FAIL %s t=%0t field_out=%b expected=%b (duty %0d slot %0d)",
                   cur_req, $time, field_out, exp, d, m_slot);
      end
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog cycles=%0d expected<=190000", cycles);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic run_periods(input int n);
    repeat (n * PER) @(negedge clk);
  endtask

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    run_cycles(5);
    rst_n = 1'b1;
    run_periods(1);

    cur_req = "R5";           // pre-excitation fixed duty
    mode = 2'd1;
    run_periods(3);

    cur_req = "R7";           // limited soft start from 48 toward 127
    mode = 2'd2; volt_err_mv = 16'sd50; ramp_sel = 4'd0; cutoff_code = 4'd0;
    run_periods(25);
    cur_req = "R2";           // ramp to full field, output held high
    volt_err_mv = 16'sd200;
    run_periods(40);

    cur_req = "R8";           // immediate decrease
    volt_err_mv = 16'sd20;
    run_periods(3);

    cur_req = "R4";           // proportional values above cutoff speed, unlimited
    cutoff_code = 4'd1; speed_rpm = 16'd5000;
    volt_err_mv = -16'sd5;  run_periods(2);
    volt_err_mv = 16'sd1;   run_periods(2);
    volt_err_mv = 16'sd99;  run_periods(2);
    volt_err_mv = 16'sd100; run_periods(2);
    volt_err_mv = 16'sd37;  run_periods(2);

    cur_req = "R9";           // exactly at cutoff: not limited
    speed_rpm = 16'd2400; volt_err_mv = 16'sd0; run_periods(2);
    volt_err_mv = 16'sd100; run_periods(2);
    speed_rpm = 16'd2399; volt_err_mv = 16'sd0; run_periods(2);
    volt_err_mv = 16'sd100; run_periods(5);
    cutoff_code = 4'd15; speed_rpm = 16'd7999; volt_err_mv = 16'sd0; run_periods(2);
    volt_err_mv = 16'sd100; run_periods(3);

    cur_req = "R3";           // mid-period change
    run_cycles(100);
    volt_err_mv = 16'sd10;
    run_cycles(100);
    volt_err_mv = 16'sd60;
    run_periods(2);

    cur_req = "R10";          // first ramp limited at high speed
    cutoff_code = 4'd1; speed_rpm = 16'd6000; volt_err_mv = 16'sd0;
    run_periods(2);
    engine_start = 1'b1; run_cycles(1); engine_start = 1'b0;
    volt_err_mv = 16'sd100;
    run_periods(70);
    volt_err_mv = 16'sd0;   run_periods(2);
    volt_err_mv = 16'sd100; run_periods(2);

    cur_req = "R7";           // slowest table entry
    cutoff_code = 4'd0; ramp_sel = 4'd15; volt_err_mv = 16'sd0; run_periods(2);
    volt_err_mv = 16'sd100; run_periods(4);

    cur_req = "R6";           // off codes
    mode = 2'd3; run_periods(2);
    mode = 2'd1; run_periods(2);
    mode = 2'd0; run_periods(2);

    cur_req = "R1";           // reset mid-stream
    mode = 2'd2; cutoff_code = 4'd1; speed_rpm = 16'd6000; volt_err_mv = 16'sd80;
    run_periods(2);
    rst_n = 1'b0; run_cycles(3); rst_n = 1'b1;
    run_periods(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule